// File: doc/BRIEF.md
# Link Negotiation Mode Control Register

This block is a single 16-bit host-visible control word that decides how an Ethernet link-establishment unit behaves. Software picks one of three operating modes: forced full duplex, plain normal link pulses, or auto-negotiation. With none of them selected the link side goes quiet. From the stored bits the block resolves one mode code and the enables for the pulse generator and transmitter. It also produces the sideband strobes that a separate negotiation engine consumes.

Host accesses arrive on a valid/ready request channel, with a registered response channel for reads. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is waiting that the host has not yet taken. A read response stays valid and unchanged until `rsp_ready` is high at a clock edge. Writes give no response. The negotiation engine reports back on three plain status pins: negotiation started, entry into ability detect, and the negotiated duplex result.

Top module: `lnk_mode_ctl`

## Requirements
- R1: After reset the word reads 0x001D. Bits 5:0 always read the identifier 6'b011101 and bits 14:10 always read zero. Writes to those bits change nothing, so writing 0xFFFF reads back 0x83DD.
- R2: A request is accepted at an edge where `req_valid` and `req_ready` are both high. A read response appears on `rsp_valid`/`rsp_rdata` after that edge and holds until an edge with `rsp_ready` high. `req_ready` is low while a response is pending and `rsp_ready` is low. An access whose `req_addr` differs from `REG_ADDR` does not write, and reads back 0.
- R3: `mode` is resolved by priority: bit 15 set gives 1 (forced full duplex), else bit 9 gives 2 (normal link pulses), else bit 8 gives 3 (auto-negotiation), else 0 (off).
- R4: `tx_en` is high exactly when `mode` is not 0. `nlp_pulse_en` is high only in mode 2 and `flp_en` only in mode 3, so with bits 15, 9 and 8 all clear no pulses are sent.
- R5: `fdx_ind` is 1 whenever bit 15 is set; otherwise it follows `neg_fdx`.
- R6: The restart request (bit 6) is effective only while bits 9 and 15 are both clear. `restart_stb` is high for exactly the one cycle in which the effective request becomes true, and a request that stays set does not retrigger it.
- R7: Bit 6 clears at an edge where `neg_started` is high, unless a write is accepted at that same edge.
- R8: `abort_stb` is high for one cycle after a write that clears bit 8 while it was set.
- R9: `adv_fdx` takes the value of bit 7 at each edge where `ability_enter` is high and holds otherwise. Its reset value is 0.
- R10: Reads have no side effects: they change no stored bit and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address of the access |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the read response |
| rsp_rdata | output | 16 | Read data |
| neg_started | input | 1 | Engine reports negotiation has begun |
| ability_enter | input | 1 | Engine is entering ability detect |
| neg_fdx | input | 1 | Negotiated duplex result, 1 for full |
| mode | output | 2 | Resolved mode code |
| tx_en | output | 1 | Transmitter enable |
| nlp_pulse_en | output | 1 | Send normal link pulses |
| flp_en | output | 1 | Allow fast link pulses and negotiation |
| restart_stb | output | 1 | One-cycle restart request to the engine |
| abort_stb | output | 1 | One-cycle abort to the engine |
| adv_fdx | output | 1 | Full-duplex advertisement sampled at ability detect |
| fdx_ind | output | 1 | Full-duplex LED and status |

## Verification
The bench sets a restart request while a higher-priority mode is active and then drops that mode. A design that ignores the gating would pulse early; one that edge-detects the raw bit would never pulse. It holds the restart bit for many cycles to catch a level-sensitive strobe, and it pulses `neg_started` to show the bit self-clears, where a broken clear would leave the request stuck. It changes bit 7 between ability-detect entries, which exposes an advertisement that tracks the register live. It also stalls the response channel to catch data that changes or requests that are accepted while stalled. Finally it writes all ones and reads the wrong address to catch writable identifier or reserved bits and a loose address decode.

// File: rtl/lnk_mode_pkg.sv
package lnk_mode_pkg;
  localparam int WORD_W   = 16;
  localparam int ID_W     = 6;
  localparam logic [ID_W-1:0] ID_VAL = 6'b011101;
  localparam int BIT_FFDX = 15;
  localparam int BIT_NLP  = 9;
  localparam int BIT_AUTO = 8;
  localparam int BIT_ADV  = 7;
  localparam int BIT_RST  = 6;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_FFDX = 2'd1,
    MODE_NLP  = 2'd2,
    MODE_AUTO = 2'd3
  } mode_t;

  typedef struct packed {
    logic force_fdx;
    logic nlp_only;
    logic auto_en;
    logic adv_req;
    logic restart_req;
  } ctl_t;
endpackage

// File: rtl/lnk_host_port.sv
module lnk_host_port #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic                                req_write,
  input  logic [ADDR_W-1:0]                   req_addr,
  output logic                                rsp_valid,
  input  logic                                rsp_ready,
  output logic [lnk_mode_pkg::WORD_W-1:0]     rsp_rdata,
  input  logic [lnk_mode_pkg::WORD_W-1:0]     rd_word,
  output logic                                wr_hit
);
  logic accept;
  logic hit;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign hit       = (req_addr == REG_ADDR);
  assign wr_hit    = accept && req_write && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= hit ? rd_word : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lnk_ctl_regs.sv
module lnk_ctl_regs
  import lnk_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wdata,
  input  logic              neg_started,
  output ctl_t              ctl,
  output logic [WORD_W-1:0] rd_word
);
  localparam int RSV_LO = BIT_NLP + 1;
  localparam int RSV_HI = BIT_FFDX - 1;

  logic unused_wbits;
  assign unused_wbits = ^{wdata[RSV_HI:RSV_LO], wdata[ID_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_hit) begin
      ctl.force_fdx   <= wdata[BIT_FFDX];
      ctl.nlp_only    <= wdata[BIT_NLP];
      ctl.auto_en     <= wdata[BIT_AUTO];
      ctl.adv_req     <= wdata[BIT_ADV];
      ctl.restart_req <= wdata[BIT_RST];
    end else if (neg_started) begin
      ctl.restart_req <= 1'b0;
    end
  end

  always_comb begin
    rd_word           = '0;
    rd_word[ID_W-1:0] = ID_VAL;
    rd_word[BIT_FFDX] = ctl.force_fdx;
    rd_word[BIT_NLP]  = ctl.nlp_only;
    rd_word[BIT_AUTO] = ctl.auto_en;
    rd_word[BIT_ADV]  = ctl.adv_req;
    rd_word[BIT_RST]  = ctl.restart_req;
  end
endmodule

// File: rtl/lnk_mode_res.sv
module lnk_mode_res
  import lnk_mode_pkg::*;
(
  input  ctl_t  ctl,
  input  logic  neg_fdx,
  output mode_t mode,
  output logic  tx_en,
  output logic  nlp_pulse_en,
  output logic  flp_en,
  output logic  fdx_ind,
  output logic  restart_eff
);
  always_comb begin
    if (ctl.force_fdx)     mode = MODE_FFDX;
    else if (ctl.nlp_only) mode = MODE_NLP;
    else if (ctl.auto_en)  mode = MODE_AUTO;
    else                   mode = MODE_OFF;
  end

  assign tx_en        = (mode != MODE_OFF);
  assign nlp_pulse_en = (mode == MODE_NLP);
  assign flp_en       = (mode == MODE_AUTO);
  assign fdx_ind      = ctl.force_fdx ? 1'b1 : neg_fdx;
  assign restart_eff  = ctl.restart_req && !ctl.nlp_only && !ctl.force_fdx;
endmodule

// File: rtl/lnk_neg_side.sv
module lnk_neg_side (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_eff,
  input  logic auto_en,
  input  logic adv_req,
  input  logic ability_enter,
  output logic restart_stb,
  output logic abort_stb,
  output logic adv_fdx
);
  logic restart_q;
  logic auto_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      restart_q <= 1'b0;
      auto_q    <= 1'b0;
      adv_fdx   <= 1'b0;
    end else begin
      restart_q <= restart_eff;
      auto_q    <= auto_en;
      if (ability_enter) adv_fdx <= adv_req;
    end
  end

  assign restart_stb = restart_eff && !restart_q;
  assign abort_stb   = auto_q && !auto_en;
endmodule

// File: rtl/lnk_mode_ctl.sv
module lnk_mode_ctl
  import lnk_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h8E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_rdata,
  input  logic              neg_started,
  input  logic              ability_enter,
  input  logic              neg_fdx,
  output logic [1:0]        mode,
  output logic              tx_en,
  output logic              nlp_pulse_en,
  output logic              flp_en,
  output logic              restart_stb,
  output logic              abort_stb,
  output logic              adv_fdx,
  output logic              fdx_ind
);
  logic              wr_hit;
  logic [WORD_W-1:0] rd_word;
  ctl_t              ctl;
  mode_t             mode_r;
  logic              restart_eff;

  lnk_host_port #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rd_word(rd_word), .wr_hit(wr_hit)
  );

  lnk_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(req_wdata),
    .neg_started(neg_started), .ctl(ctl), .rd_word(rd_word)
  );

  lnk_mode_res u_res (
    .ctl(ctl), .neg_fdx(neg_fdx), .mode(mode_r), .tx_en(tx_en),
    .nlp_pulse_en(nlp_pulse_en), .flp_en(flp_en), .fdx_ind(fdx_ind),
    .restart_eff(restart_eff)
  );

  lnk_neg_side u_side (
    .clk(clk), .rst_n(rst_n), .restart_eff(restart_eff),
    .auto_en(ctl.auto_en), .adv_req(ctl.adv_req),
    .ability_enter(ability_enter), .restart_stb(restart_stb),
    .abort_stb(abort_stb), .adv_fdx(adv_fdx)
  );

  assign mode = mode_r;
endmodule

// File: rtl/lnk_mode_ctl_chk.sv
module lnk_mode_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        req_ready,
  input logic [15:0] rsp_rdata,
  input logic [1:0]  mode,
  input logic        fdx_ind,
  input logic        restart_stb,
  input logic        abort_stb,
  input logic        ability_enter,
  input logic        adv_fdx
);
  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  // R2
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  // R1
  id_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[5:0] == 6'b011101 || rsp_rdata == 16'h0000));
  // R5
  forced_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd1 |-> fdx_ind);
  // R6
  restart_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_stb |=> !restart_stb);
  // R8
  abort_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_stb |=> !abort_stb);
  // R9
  adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ability_enter |=> $stable(adv_fdx));
endmodule

bind lnk_mode_ctl lnk_mode_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mode(mode),
  .fdx_ind(fdx_ind), .restart_stb(restart_stb), .abort_stb(abort_stb),
  .ability_enter(ability_enter), .adv_fdx(adv_fdx)
);

// File: tb/test_lnk_mode_ctl.sv
`timescale 1ns/1ps
module test_lnk_mode_ctl;
  localparam logic [7:0] RA = 8'h8E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic neg_started = 1'b0, ability_enter = 1'b0, neg_fdx = 1'b0;
  logic req_ready, rsp_valid, tx_en, nlp_pulse_en, flp_en;
  logic restart_stb, abort_stb, adv_fdx, fdx_ind;
  logic [15:0] rsp_rdata;
  logic [1:0] mode;
  int errors = 0, checks = 0;
  logic [15:0] rd;

  always #10 clk = ~clk;

  lnk_mode_ctl #(.ADDR_W(8), .REG_ADDR(RA)) i_lnk_mode_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .neg_started(neg_started), .ability_enter(ability_enter), .neg_fdx(neg_fdx),
    .mode(mode), .tx_en(tx_en), .nlp_pulse_en(nlp_pulse_en), .flp_en(flp_en),
    .restart_stb(restart_stb), .abort_stb(abort_stb), .adv_fdx(adv_fdx),
    .fdx_ind(fdx_ind)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rdreg(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic t_reset();
    chk("R3 reset mode", {14'b0, mode}, 16'd0);
    chk("R4 reset tx_en", {15'b0, tx_en}, 16'd0);
    chk("R9 reset adv", {15'b0, adv_fdx}, 16'd0);
    rdreg(RA, rd);
    chk("R1 reset word", rd, 16'h001D);
  endtask

  task automatic t_fixed_bits();
    wr(RA, 16'hFFFF);
    rdreg(RA, rd);
    chk("R1 all-ones readback", rd, 16'h83DD);
    wr(RA, 16'h0000);
    rdreg(RA, rd);
    chk("R1 zero readback", rd, 16'h001D);
  endtask

  task automatic t_priority();
    wr(RA, 16'h0100);
    chk("R3 auto mode", {14'b0, mode}, 16'd3);
    chk("R4 flp_en", {13'b0, tx_en, nlp_pulse_en, flp_en}, 16'b101);
    wr(RA, 16'h0300);
    chk("R3 nlp over auto", {14'b0, mode}, 16'd2);
    chk("R4 nlp pulses", {13'b0, tx_en, nlp_pulse_en, flp_en}, 16'b110);
    wr(RA, 16'h8300);
    chk("R3 force over all", {14'b0, mode}, 16'd1);
    chk("R4 forced no pulses", {13'b0, tx_en, nlp_pulse_en, flp_en}, 16'b100);
    wr(RA, 16'h0000);
    chk("R4 off silent", {13'b0, tx_en, nlp_pulse_en, flp_en}, 16'b000);
  endtask

  task automatic t_fdx();
    neg_fdx = 1'b0;
    wr(RA, 16'h8000);
    chk("R5 forced fdx", {15'b0, fdx_ind}, 16'd1);
    wr(RA, 16'h0100);
    #1;
    chk("R5 follows 0", {15'b0, fdx_ind}, 16'd0);
    neg_fdx = 1'b1; #1;
    chk("R5 follows 1", {15'b0, fdx_ind}, 16'd1);
    neg_fdx = 1'b0;
  endtask

  task automatic t_restart();
    wr(RA, 16'h0140);
    chk("R6 strobe on rise", {15'b0, restart_stb}, 16'd1);
    @(negedge clk);
    chk("R6 strobe one cycle", {15'b0, restart_stb}, 16'd0);
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk("R6 held no retrigger", {15'b0, restart_stb}, 16'd0);
    rdreg(RA, rd);
    chk("R10 read keeps bit6", rd, 16'h015D);
    chk("R10 read no strobe", {15'b0, restart_stb}, 16'd0);
    neg_started = 1'b1;
    @(negedge clk);
    neg_started = 1'b0;
    rdreg(RA, rd);
    chk("R7 bit6 self-clears", rd, 16'h011D);
    wr(RA, 16'h0140);
    chk("R6 new strobe after clear", {15'b0, restart_stb}, 16'd1);
    wr(RA, 16'h0100);
  endtask

  task automatic t_restart_gated();
    wr(RA, 16'h0340);
    chk("R6 gated by nlp", {15'b0, restart_stb}, 16'd0);
    wr(RA, 16'h8140);
    chk("R6 gated by force", {15'b0, restart_stb}, 16'd0);
    wr(RA, 16'h0140);
    chk("R6 strobe when gate drops", {15'b0, restart_stb}, 16'd1);
    wr(RA, 16'h0100);
  endtask

  task automatic t_abort();
    wr(RA, 16'h0100);
    chk("R8 no abort while set", {15'b0, abort_stb}, 16'd0);
    wr(RA, 16'h0000);
    chk("R8 abort on clear", {15'b0, abort_stb}, 16'd1);
    @(negedge clk);
    chk("R8 abort one cycle", {15'b0, abort_stb}, 16'd0);
  endtask

  task automatic t_adv();
    wr(RA, 16'h0180);
    chk("R9 not yet sampled", {15'b0, adv_fdx}, 16'd0);
    ability_enter = 1'b1;
    @(negedge clk);
    ability_enter = 1'b0;
    chk("R9 sampled 1", {15'b0, adv_fdx}, 16'd1);
    wr(RA, 16'h0100);
    chk("R9 later write ignored", {15'b0, adv_fdx}, 16'd1);
    ability_enter = 1'b1;
    @(negedge clk);
    ability_enter = 1'b0;
    chk("R9 resampled 0", {15'b0, adv_fdx}, 16'd0);
  endtask

  task automatic t_handshake();
    rsp_ready = 1'b0;
    rdreg(RA, rd);
    chk("R2 rsp valid", {15'b0, rsp_valid}, 16'd1);
    @(negedge clk);
    chk("R2 held under stall", {rsp_valid, req_ready, 14'b0}, 16'h8000);
    chk("R2 data held", rsp_rdata, 16'h011D);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R2 released", {rsp_valid, req_ready, 14'b0}, 16'h4000);
  endtask

  task automatic t_addr_miss();
    wr(RA + 8'd1, 16'h8000);
    chk("R2 miss write ignored", {14'b0, mode}, 16'd3);
    rdreg(RA + 8'd1, rd);
    chk("R2 miss read zero", rd, 16'h0000);
    rdreg(RA, rd);
    chk("R2 reg unchanged", rd, 16'h011D);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed_bits();
    t_priority();
    t_fdx();
    t_restart();
    t_restart_gated();
    t_abort();
    wr(RA, 16'h0100);
    t_adv();
    t_handshake();
    t_addr_miss();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule